// File: doc/BRIEF.md
# UTOPIA Receive Multi-PHY Availability Responder

This block answers availability polls from an ATM layer device on a receive bus shared by several PHYs. On every rising clock edge it registers the polling address and compares it with a programmable local address. A match turns on its output enable for the following cycle. With no match the output stays undriven, so other PHYs on the bus can answer.

Receive FIFO fill is tracked by a saturating counter. The write side of the FIFO sends it one strobe per byte or word, and the read side does the same. The counter does not model the FIFO storage.

The block has two modes. In cell mode the driven value is a level: it is high while at least one whole cell is held. In packet mode the driven value is a one-cycle pulse. The pulse is armed when the buffered byte count reaches a programmable threshold, and it is given at the next poll of this PHY. Tri-state is modelled as a separate enable output, so a wrapper at the pad can build the buffer.

Top module: `utopia_rx_avail`

## Requirements
- R1: `avail_oe_o` is high in the cycle after a rising edge at which `poll_addr_i` equalled `local_addr_i`, and low after any edge with no match.
- R2: `avail_o` is low whenever `avail_oe_o` is low.
- R3: Occupancy rises by one per `wr_stb_i` cycle below `DEPTH` and falls by one per `rd_stb_i` cycle above zero. It saturates at `DEPTH` and at zero.
- R4: In cell mode (`pkt_mode_i`=0) with 8-bit units (`wide_i`=0), a polled `avail_o` is high exactly when occupancy is at least 53.
- R5: In cell mode with 16-bit units (`wide_i`=1), a polled `avail_o` is high exactly when occupancy is at least 27 words.
- R6: In packet mode (`pkt_mode_i`=1), the buffered byte count rising to at least `pkt_thresh_i` arms a pulse. At the next polled cycle `avail_o` is high for that one cycle and then low.
- R7: An armed pulse is dropped if the byte count falls below the threshold, or if `pkt_mode_i`, `wide_i` or `pkt_thresh_i` changes. Staying at or above the threshold after such a change does not re-arm the pulse.
- R8: While `rst_ni` is low, `avail_oe_o` and `avail_o` are low and occupancy is cleared.
- R9: In 16-bit units, the byte count compared with the threshold is twice the word occupancy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive interface clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| poll_addr_i | input | ADDR_W | Polling address from the ATM layer |
| local_addr_i | input | ADDR_W | Programmed address of this PHY |
| pkt_mode_i | input | 1 | 0 = cell level, 1 = packet pulse |
| wide_i | input | 1 | 0 = byte units, 1 = 16-bit word units |
| pkt_thresh_i | input | OCC_W+1 | Packet-mode byte threshold |
| wr_stb_i | input | 1 | FIFO write-side unit strobe |
| rd_stb_i | input | 1 | FIFO read-side unit strobe |
| avail_o | output | 1 | Cell-available level or packet-available pulse |
| avail_oe_o | output | 1 | Drive enable for avail_o |

## Verification
The tests go after the cell boundary one unit short of a full cell and at a full cell, in both unit widths. A wrong size constant would make the flag appear a unit early or late. Occupancy is driven past both ends and then moved back across the cell boundary; a counter that wraps would report a cell that is not there. In packet mode the tests check that the pulse waits for a poll, lasts exactly one cycle, and is discarded after a threshold change, a mode toggle or a drain below the threshold. A design that got these wrong would stretch the pulse, lose it, or fire a stale one.

// File: rtl/utopia_rx_pkg.sv
package utopia_rx_pkg;
  localparam int unsigned CELL_UNITS_8  = 53;
  localparam int unsigned CELL_UNITS_16 = 27;

  typedef enum logic {
    AV_CELL = 1'b0,
    AV_PKT  = 1'b1
  } av_mode_e;
endpackage

// File: rtl/rx_addr_match.sv
module rx_addr_match #(
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  output logic              hit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_o <= 1'b0;
    else         hit_o <= (poll_addr_i == local_addr_i);
  end
endmodule

// File: rtl/rx_occ_counter.sv
module rx_occ_counter #(
  parameter int DEPTH = 128,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [OCC_W-1:0] occ_o
);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic inc, dec;
  assign inc = wr_i && (occ_o != FULL);
  assign dec = rd_i && (occ_o != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         occ_o <= '0;
    else if (inc && !dec) occ_o <= occ_o + 1'b1;
    else if (dec && !inc) occ_o <= occ_o - 1'b1;
  end
endmodule

// File: rtl/rx_avail_decide.sv
module rx_avail_decide
  import utopia_rx_pkg::*;
#(
  parameter int OCC_W = 8,
  localparam int TH_W = OCC_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [OCC_W-1:0] occ_i,
  input  av_mode_e         mode_i,
  input  logic             wide_i,
  input  logic [TH_W-1:0]  thresh_i,
  output logic             avail_o
);
  localparam logic [OCC_W-1:0] CELL_N8  = OCC_W'(CELL_UNITS_8);
  localparam logic [OCC_W-1:0] CELL_N16 = OCC_W'(CELL_UNITS_16);

  av_mode_e        mode_q;
  logic            wide_q, cond_q, pend_q;
  logic [TH_W-1:0] thr_q, bytes;
  logic            cell_ok, cond, cfg_chg;

  assign cell_ok = wide_i ? (occ_i >= CELL_N16) : (occ_i >= CELL_N8);
  assign bytes   = wide_i ? {occ_i, 1'b0} : {1'b0, occ_i};
  assign cond    = bytes >= thresh_i;
  assign cfg_chg = (mode_i != mode_q) || (wide_i != wide_q) || (thresh_i != thr_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= AV_CELL;
      wide_q <= 1'b0;
      thr_q  <= '0;
      cond_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_i;
      wide_q <= wide_i;
      thr_q  <= thresh_i;
      cond_q <= cond;
      // clear beats arm; arm only on a fresh crossing
      if (cfg_chg || !cond)              pend_q <= 1'b0;
      else if (!cond_q)                  pend_q <= 1'b1;
      else if (hit_i && mode_i == AV_PKT) pend_q <= 1'b0;
    end
  end

  assign avail_o = hit_i && ((mode_i == AV_PKT) ? pend_q : cell_ok);
endmodule

// File: rtl/utopia_rx_avail.sv
module utopia_rx_avail
  import utopia_rx_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 128,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  input  logic              pkt_mode_i,
  input  logic              wide_i,
  input  logic [OCC_W:0]    pkt_thresh_i,
  input  logic              wr_stb_i,
  input  logic              rd_stb_i,
  output logic              avail_o,
  output logic              avail_oe_o
);
  logic             hit;
  logic [OCC_W-1:0] occ;

  rx_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .poll_addr_i(poll_addr_i), .local_addr_i(local_addr_i),
    .hit_o(hit)
  );

  rx_occ_counter #(.DEPTH(DEPTH)) u_occ (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr_stb_i), .rd_i(rd_stb_i),
    .occ_o(occ)
  );

  rx_avail_decide #(.OCC_W(OCC_W)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hit_i(hit), .occ_i(occ),
    .mode_i(av_mode_e'(pkt_mode_i)), .wide_i(wide_i),
    .thresh_i(pkt_thresh_i),
    .avail_o(avail_o)
  );

  assign avail_oe_o = hit;
endmodule

// File: rtl/utopia_rx_avail_chk.sv
module utopia_rx_avail_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] poll_addr_i,
  input logic [ADDR_W-1:0] local_addr_i,
  input logic              pkt_mode_i,
  input logic              avail_o,
  input logic              avail_oe_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  // R1
  oe_follows_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (avail_oe_o == $past(poll_addr_i == local_addr_i)));

  // R2
  undriven_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !avail_oe_o |-> !avail_o);

  // R6
  pkt_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_mode_i && avail_o) |=> (!avail_o || !pkt_mode_i));

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!avail_oe_o && !avail_o);
    end
  end
endmodule

bind utopia_rx_avail utopia_rx_avail_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .poll_addr_i(poll_addr_i), .local_addr_i(local_addr_i),
  .pkt_mode_i(pkt_mode_i), .avail_o(avail_o), .avail_oe_o(avail_oe_o)
);

// File: tb/utopia_rx_avail_test.sv
module utopia_rx_avail_test;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 128;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam logic [ADDR_W-1:0] MY  = 5'd9;
  localparam logic [ADDR_W-1:0] OTH = 5'd3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] poll_addr_i = OTH;
  logic [ADDR_W-1:0] local_addr_i = MY;
  logic              pkt_mode_i = 1'b0;
  logic              wide_i = 1'b0;
  logic [OCC_W:0]    pkt_thresh_i = '0;
  logic              wr_stb_i = 1'b0;
  logic              rd_stb_i = 1'b0;
  logic              avail_o, avail_oe_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  utopia_rx_avail #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic push(input int n);
    wr_stb_i = 1'b1; cyc(n); wr_stb_i = 1'b0;
  endtask

  task automatic pull(input int n);
    rd_stb_i = 1'b1; cyc(n); rd_stb_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; wr_stb_i = 1'b0; rd_stb_i = 1'b0; poll_addr_i = MY;
    cyc(2);
    chk("R8 oe in reset", avail_oe_o, 1'b0);
    chk("R8 avail in reset", avail_o, 1'b0);
    rst_ni = 1'b1; poll_addr_i = OTH;
    cyc(1);
  endtask

  task automatic t_addr();
    do_reset();
    poll_addr_i = MY; cyc(1);
    chk("R1 oe after match", avail_oe_o, 1'b1);
    poll_addr_i = OTH;
    chk("R1 oe held until edge", avail_oe_o, 1'b1);
    cyc(1);
    chk("R1 oe after mismatch", avail_oe_o, 1'b0);
    chk("R2 avail undriven", avail_o, 1'b0);
  endtask

  task automatic t_cell_8();
    do_reset();
    pkt_mode_i = 1'b0; wide_i = 1'b0; poll_addr_i = MY;
    push(52);
    chk("R4 52 bytes", avail_o, 1'b0);
    push(1);
    chk("R4 53 bytes", avail_o, 1'b1);
    poll_addr_i = OTH; cyc(1);
    chk("R2 oe off with cell", avail_oe_o, 1'b0);
    chk("R2 avail off with cell", avail_o, 1'b0);
    poll_addr_i = MY;
    pull(1);
    chk("R4 back to 52", avail_o, 1'b0);
  endtask

  task automatic t_cell_16();
    do_reset();
    pkt_mode_i = 1'b0; wide_i = 1'b1; poll_addr_i = MY;
    push(26);
    chk("R5 26 words", avail_o, 1'b0);
    push(1);
    chk("R5 27 words", avail_o, 1'b1);
    wide_i = 1'b0;
  endtask

  task automatic t_sat();
    do_reset();
    pkt_mode_i = 1'b0; wide_i = 1'b0; poll_addr_i = MY;
    pull(5);
    push(52);
    chk("R3 empty saturation 52", avail_o, 1'b0);
    push(1);
    chk("R3 empty saturation 53", avail_o, 1'b1);
    push(150);
    pull(76);
    chk("R3 full saturation 52", avail_o, 1'b0);
    push(1);
    chk("R3 full saturation 53", avail_o, 1'b1);
  endtask

  task automatic t_pkt();
    do_reset();
    pkt_mode_i = 1'b1; wide_i = 1'b0; pkt_thresh_i = 40;
    poll_addr_i = OTH; cyc(2);
    push(39); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R6 below threshold oe", avail_oe_o, 1'b1);
    chk("R6 below threshold", avail_o, 1'b0);
    poll_addr_i = OTH;
    push(1); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R6 pulse at poll", avail_o, 1'b1);
    cyc(1);
    chk("R6 pulse one cycle", avail_o, 1'b0);
    cyc(1);
    chk("R6 no repeat", avail_o, 1'b0);
  endtask

  task automatic t_pkt_wide();
    do_reset();
    pkt_mode_i = 1'b1; wide_i = 1'b1; pkt_thresh_i = 40;
    poll_addr_i = OTH; cyc(2);
    push(19); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R9 38 bytes", avail_o, 1'b0);
    poll_addr_i = OTH;
    push(1); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R9 40 bytes", avail_o, 1'b1);
    wide_i = 1'b0;
  endtask

  task automatic t_pkt_clear();
    do_reset();
    pkt_mode_i = 1'b1; wide_i = 1'b0; pkt_thresh_i = 10;
    poll_addr_i = OTH; cyc(2);
    push(10); cyc(2);
    pkt_thresh_i = 8; cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R7 threshold change", avail_o, 1'b0);

    do_reset();
    pkt_thresh_i = 10; poll_addr_i = OTH; cyc(2);
    push(10); cyc(2);
    pull(1); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R7 drained below", avail_o, 1'b0);
    poll_addr_i = OTH;
    push(1); cyc(2);
    poll_addr_i = MY; cyc(1);
    chk("R6 rearm after drain", avail_o, 1'b1);

    do_reset();
    pkt_thresh_i = 10; poll_addr_i = OTH; cyc(2);
    push(10); cyc(2);
    pkt_mode_i = 1'b0; cyc(1);
    pkt_mode_i = 1'b1; cyc(1);
    poll_addr_i = MY; cyc(1);
    chk("R7 mode toggle", avail_o, 1'b0);
  endtask

  initial begin
    cyc(2);
    t_addr();
    t_cell_8();
    t_cell_16();
    t_sat();
    t_pkt();
    t_pkt_wide();
    t_pkt_clear();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule